// File: doc/BRIEF.md
# Phase-Coherent FSK Tone Synthesizer

This block turns a fixed reference clock into a stream of signed sine samples at one of four transmit tones. The tone is picked by two inputs: a mode bit that chooses the originate or answer band, and a data bit that chooses the space or mark tone inside that band. A divider whose length alternates between N and N+1 cycles produces step strobes. The fraction that sets how often the longer length is used comes from a fixed-width accumulator, so the mean step rate comes close to 32 times the tone frequency even when the clock is not an exact multiple of it.

Each step moves a 5-bit phase index forward by one position. The index addresses a 32-point sine table computed from a quarter wave. A new tone is taken up only at a step boundary. When the tone changes, the phase index and the fractional accumulator keep their values, so the waveform has no discontinuity and the bit edge lands within one step period. A downstream reconstruction filter and line driver consume the samples.

Top module: `fsk_tone_synth`

## Requirements
- R1: The tone index is {mode_i, data_i}. Index 0 is 1070 Hz, 1 is 1270 Hz, 2 is 2025 Hz and 3 is 2225 Hz. With a tone held, the mean step rate is 32 times that frequency: 128 consecutive step periods span 128·CLK_HZ/(32·f) clock cycles, within ±2 cycles.
- R2: For a tone of frequency f, N = floor(CLK_HZ/(32·f)) and the 16-bit increment is round(((CLK_HZ mod 32·f)·2^16)/(32·f)). Each step period is N+1 cycles if adding the increment to the 16-bit accumulator carries out, and N cycles otherwise. Two step strobes never occur in adjacent cycles.
- R3: Every step advances phase_o by exactly one, and the index wraps from 31 to 0.
- R4: sample_o is an 8-bit two's complement value equal to round(127·sin(2π·phase_o/32)), rounding halves away from zero. It is positive for phases 1..15, negative for 17..31, and zero at 0 and 16.
- R5: The inputs are sampled only in the cycle that ends a step period. A change at any other time has no effect on the period in progress, and tone_o shows the tone currently in force.
- R6: At a tone change the phase index continues from its current value (previous value plus one) and the fractional accumulator is not cleared.
- R7: rst_n low asynchronously clears the phase, sample, step strobe, tone, divider count and accumulator. Release passes through a two-stage synchronizer, so the first step strobe is seen after the third rising edge that follows the release.
- R8: step_o is high for exactly one cycle, in the cycle right after phase_o and sample_o have changed. They do not change in any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode_i | input | 1 | Band select: 0 originate, 1 answer |
| data_i | input | 1 | Transmit bit: 0 space, 1 mark |
| sample_o | output | 8 | Signed sine sample |
| phase_o | output | 5 | Current phase index |
| step_o | output | 1 | One-cycle strobe: phase and sample were just updated |
| tone_o | output | 2 | Tone index currently in force |

## Verification
The hazardous coincidence is a change on the selection inputs in the very cycle that ends a step period. At that point the divider must take the new tone's divisor and increment for the period that is just starting. A change one cycle later must wait a full period before it applies. The bench keeps its own model of the count, so it can place a data toggle exactly on a boundary cycle, and also one cycle after one. It then checks tone_o, the length of the following period, and the phase continuity across the switch against values it computes itself.

// File: rtl/fsk_tone_pkg.sv
package fsk_tone_pkg;

  localparam int unsigned PHASE_W         = 5;
  localparam int unsigned SAMPLE_W        = 8;
  localparam int unsigned TONES           = 4;
  localparam int unsigned TONE_W          = $clog2(TONES);
  localparam int unsigned STEPS_PER_CYCLE = 1 << PHASE_W;

  typedef logic [PHASE_W-1:0]         phase_t;
  typedef logic signed [SAMPLE_W-1:0] sample_t;
  typedef logic [TONE_W-1:0]          tone_t;

  // whole part of the clock cycles per sample step
  function automatic longint unsigned tone_div(input longint unsigned clk_hz,
                                               input longint unsigned freq);
    longint unsigned rate;
    rate = longint'(STEPS_PER_CYCLE) * freq;
    return clk_hz / rate;
  endfunction

  // fractional part of the step length, scaled to frac_w bits and rounded
  function automatic longint unsigned tone_inc(input longint unsigned clk_hz,
                                               input longint unsigned freq,
                                               input int unsigned     frac_w);
    longint unsigned rate;
    longint unsigned rem;
    longint unsigned val;
    longint unsigned lim;
    rate = longint'(STEPS_PER_CYCLE) * freq;
    rem  = clk_hz % rate;
    val  = ((rem << frac_w) + rate / 2) / rate;
    lim  = (longint'(1) << frac_w) - 1;
    if (val > lim) val = lim;
    return val;
  endfunction

  // first quadrant of the wave, k = 0..8 of 32 points per cycle
  function automatic sample_t quarter_wave(input logic [3:0] k);
    sample_t v;
    case (k)
      4'd0:    v = 8'sd0;
      4'd1:    v = 8'sd25;
      4'd2:    v = 8'sd49;
      4'd3:    v = 8'sd71;
      4'd4:    v = 8'sd90;
      4'd5:    v = 8'sd106;
      4'd6:    v = 8'sd117;
      4'd7:    v = 8'sd125;
      default: v = 8'sd127;
    endcase
    return v;
  endfunction

  // full cycle folded onto the quadrant table by symmetry
  function automatic sample_t sine_at(input phase_t p);
    logic [3:0] k;
    sample_t    mag;
    if (p[PHASE_W-2]) k = 4'd8 - {1'b0, p[PHASE_W-3:0]};
    else              k = {1'b0, p[PHASE_W-3:0]};
    mag = quarter_wave(k);
    return p[PHASE_W-1] ? -mag : mag;
  endfunction

endpackage

// File: rtl/fsk_tone_table.sv
module fsk_tone_table
  import fsk_tone_pkg::*;
#(
  parameter int unsigned CLK_HZ = 3_686_400,
  parameter int unsigned FREQ0  = 1070,
  parameter int unsigned FREQ1  = 1270,
  parameter int unsigned FREQ2  = 2025,
  parameter int unsigned FREQ3  = 2225,
  parameter int unsigned FRAC_W = 16,
  parameter int unsigned CNT_W  = 7
)(
  input  tone_t             sel_i,
  output logic [CNT_W-1:0]  div_o,
  output logic [FRAC_W-1:0] inc_o
);

  localparam int unsigned FREQ [TONES] = '{FREQ0, FREQ1, FREQ2, FREQ3};

  logic [CNT_W-1:0]  div_tab [TONES];
  logic [FRAC_W-1:0] inc_tab [TONES];

  for (genvar t = 0; t < TONES; t++) begin : g_tone
    localparam longint unsigned DIV = tone_div(CLK_HZ, FREQ[t]);
    localparam longint unsigned INC = tone_inc(CLK_HZ, FREQ[t], FRAC_W);
    assign div_tab[t] = CNT_W'(DIV);
    assign inc_tab[t] = FRAC_W'(INC);
  end

  assign div_o = div_tab[sel_i];
  assign inc_o = inc_tab[sel_i];

endmodule

// File: rtl/fsk_dual_mod_div.sv
module fsk_dual_mod_div
  import fsk_tone_pkg::*;
#(
  parameter int unsigned CNT_W  = 7,
  parameter int unsigned FRAC_W = 16
)(
  input  logic              clk,
  input  logic              rst_n,
  input  tone_t             sel_i,
  input  logic [CNT_W-1:0]  div_i,
  input  logic [FRAC_W-1:0] inc_i,
  output logic              tick_o,
  output tone_t             tone_o
);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [FRAC_W-1:0] acc_q, acc_d;
  tone_t             tone_q, tone_d;
  logic [FRAC_W:0]   sum;
  logic              boundary;

  assign boundary = (cnt_q == '0);
  assign sum      = {1'b0, acc_q} + {1'b0, inc_i};

  always_comb begin
    cnt_d  = cnt_q;
    acc_d  = acc_q;
    tone_d = tone_q;
    if (boundary) begin
      tone_d = sel_i;
      acc_d  = sum[FRAC_W-1:0];
      cnt_d  = div_i - CNT_W'(1) + {{(CNT_W-1){1'b0}}, sum[FRAC_W]};
    end else begin
      cnt_d  = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      acc_q  <= '0;
      tone_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      acc_q  <= acc_d;
      tone_q <= tone_d;
    end
  end

  assign tick_o = boundary;
  assign tone_o = tone_q;

endmodule

// File: rtl/fsk_phase_sine.sv
module fsk_phase_sine
  import fsk_tone_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    adv_i,
  output phase_t  phase_o,
  output sample_t sample_o,
  output logic    step_o
);

  phase_t  phase_q, phase_d;
  sample_t sample_q, sample_d;
  logic    step_q;

  always_comb begin
    phase_d  = phase_q;
    sample_d = sample_q;
    if (adv_i) begin
      phase_d  = phase_q + PHASE_W'(1);
      sample_d = sine_at(phase_d);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= '0;
      sample_q <= '0;
      step_q   <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      sample_q <= sample_d;
      step_q   <= adv_i;
    end
  end

  assign phase_o  = phase_q;
  assign sample_o = sample_q;
  assign step_o   = step_q;

endmodule

// File: rtl/fsk_tone_synth.sv
module fsk_tone_synth
  import fsk_tone_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 3_686_400,
  parameter int unsigned F_ORG_SPACE = 1070,
  parameter int unsigned F_ORG_MARK  = 1270,
  parameter int unsigned F_ANS_SPACE = 2025,
  parameter int unsigned F_ANS_MARK  = 2225,
  parameter int unsigned FRAC_W      = 16
)(
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      mode_i,
  input  logic                                      data_i,
  output logic signed [fsk_tone_pkg::SAMPLE_W-1:0]  sample_o,
  output logic [fsk_tone_pkg::PHASE_W-1:0]          phase_o,
  output logic                                      step_o,
  output logic [1:0]                                tone_o
);

  localparam int unsigned F_LO_ORG = (F_ORG_SPACE < F_ORG_MARK) ? F_ORG_SPACE : F_ORG_MARK;
  localparam int unsigned F_LO_ANS = (F_ANS_SPACE < F_ANS_MARK) ? F_ANS_SPACE : F_ANS_MARK;
  localparam int unsigned F_MIN    = (F_LO_ORG < F_LO_ANS) ? F_LO_ORG : F_LO_ANS;
  localparam longint unsigned DIV_MAX = tone_div(CLK_HZ, F_MIN);
  localparam int unsigned CNT_W    = $clog2(DIV_MAX + 1);
  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = sync_q[SYNC_STAGES-1];

  tone_t             sel;
  logic [CNT_W-1:0]  div_val;
  logic [FRAC_W-1:0] inc_val;
  logic              tick;
  tone_t             tone_cur;

  assign sel = {mode_i, data_i};

  fsk_tone_table #(
    .CLK_HZ (CLK_HZ),
    .FREQ0  (F_ORG_SPACE),
    .FREQ1  (F_ORG_MARK),
    .FREQ2  (F_ANS_SPACE),
    .FREQ3  (F_ANS_MARK),
    .FRAC_W (FRAC_W),
    .CNT_W  (CNT_W)
  ) table_i (
    .sel_i (sel),
    .div_o (div_val),
    .inc_o (inc_val)
  );

  fsk_dual_mod_div #(
    .CNT_W  (CNT_W),
    .FRAC_W (FRAC_W)
  ) div_i (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .sel_i  (sel),
    .div_i  (div_val),
    .inc_i  (inc_val),
    .tick_o (tick),
    .tone_o (tone_cur)
  );

  fsk_phase_sine wave_i (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .adv_i    (tick),
    .phase_o  (phase_o),
    .sample_o (sample_o),
    .step_o   (step_o)
  );

  assign tone_o = tone_cur;

endmodule

// File: rtl/fsk_tone_synth_chk.sv
module fsk_tone_synth_chk
  import fsk_tone_pkg::*;
(
  input logic                       clk,
  input logic                       rst_n,
  input logic                       step,
  input logic [PHASE_W-1:0]         phase,
  input logic signed [SAMPLE_W-1:0] sample,
  input logic [1:0]                 tone
);

  assert_phase_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (phase == $past(phase) + PHASE_W'(1)));

  assert_phase_still_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !step |-> ($stable(phase) && $stable(sample)));

  assert_step_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> !step);

  assert_tone_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !step |-> $stable(tone));

  assert_sample_pos_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!phase[PHASE_W-1] && phase[PHASE_W-2:0] != '0) |-> (sample > 0));

  assert_sample_neg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase[PHASE_W-1] && phase[PHASE_W-2:0] != '0) |-> (sample < 0));

  assert_sample_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase[PHASE_W-2:0] == '0) |-> (sample == 0));

endmodule

bind fsk_tone_synth fsk_tone_synth_chk chk_i (
  .clk    (clk),
  .rst_n  (rst_n),
  .step   (step_o),
  .phase  (phase_o),
  .sample (sample_o),
  .tone   (tone_o)
);

// File: tb/fsk_tone_synth_tb_top.sv
module fsk_tone_synth_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 195000;
  localparam longint CLK_HZ = 3686400;
  localparam int FW = 16;

  logic clk;
  logic rst_n;
  logic mode;
  logic data;
  logic signed [7:0] sample_o;
  logic [4:0] phase_o;
  logic step_o;
  logic [1:0] tone_o;

  int errors = 0;
  int checks = 0;

  int freq_tab [4] = '{1070, 1270, 2025, 2225};
  int n_tab [4];
  int i_tab [4];

  // reference model state
  int m_cnt, m_acc, m_tone, m_phase, m_sample, m_step;
  bit m_s1, m_s2;

  int per_cnt;
  bit per_valid;
  int per_tone;
  int last_phase;
  int last_tone;

  fsk_tone_synth dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_i   (mode),
    .data_i   (data),
    .sample_o (sample_o),
    .phase_o  (phase_o),
    .step_o   (step_o),
    .tone_o   (tone_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int exp_sine(input int p);
    real v;
    v = 127.0 * $sin(2.0 * 3.141592653589793 * p / 32.0);
    if (v >= 0.0) return $rtoi(v + 0.5);
    else          return $rtoi(v - 0.5);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic model_reset();
    m_cnt = 0; m_acc = 0; m_tone = 0; m_phase = 0; m_sample = 0; m_step = 0;
  endtask

  task automatic model_edge();
    bit s2_old;
    int sel, sum, c;
    s2_old = m_s2;
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0;
      model_reset();
    end else begin
      if (!s2_old) begin
        model_reset();
      end else if (m_cnt == 0) begin
        sel = {mode, data};
        sum = m_acc + i_tab[sel];
        c = (sum >= 65536) ? 1 : 0;
        m_acc = sum % 65536;
        m_cnt = n_tab[sel] - 1 + c;
        m_tone = sel;
        m_phase = (m_phase + 1) % 32;
        m_sample = exp_sine(m_phase);
        m_step = 1;
      end else begin
        m_cnt--;
        m_step = 0;
      end
      m_s2 = m_s1; m_s1 = 1;
    end
  endtask

  task automatic cyc();
    model_edge();
    @(negedge clk);
    check("R8 step", int'(step_o), m_step);
    check("R3 phase", int'(phase_o), m_phase);
    check("R4 sample", int'(sample_o), m_sample);
    check("R5 tone", int'(tone_o), m_tone);
    if (!rst_n || !m_s2) begin
      per_valid = 0; per_cnt = 0; last_phase = 0; last_tone = 0;
    end else begin
      per_cnt++;
      if (step_o) begin
        if (per_valid) begin
          checks++;
          if (per_cnt != n_tab[per_tone] && per_cnt != n_tab[per_tone] + 1) begin
            errors++;
            $display("FAIL R2 period: actual %0d expected %0d or %0d",
                     per_cnt, n_tab[per_tone], n_tab[per_tone] + 1);
          end
        end
        if (int'(tone_o) != last_tone)
          check("R6 phase continues across tone change", int'(phase_o), (last_phase + 1) % 32);
        per_valid = 1; per_cnt = 0; per_tone = tone_o;
        last_tone = tone_o;
      end
      last_phase = phase_o;
    end
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG_CYCLES);
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    int r;
    int sel_new;
    int cycles;
    real expc;
    for (int t = 0; t < 4; t++) begin
      longint rate, rem;
      rate = 32 * longint'(freq_tab[t]);
      n_tab[t] = int'(CLK_HZ / rate);
      rem = CLK_HZ % rate;
      i_tab[t] = int'(((rem * 65536) + rate / 2) / rate);
      if (i_tab[t] > 65535) i_tab[t] = 65535;
    end
    r = $urandom(32'd20240611);
    m_s1 = 0; m_s2 = 0; model_reset();
    per_valid = 0; per_cnt = 0; per_tone = 0; last_phase = 0; last_tone = 0;
    mode = 1'b0; data = 1'b0; rst_n = 1'b0;
    repeat (4) cyc();
    // R7: reset state
    check("R7 reset phase", int'(phase_o), 0);
    check("R7 reset sample", int'(sample_o), 0);
    check("R7 reset step", int'(step_o), 0);
    check("R7 reset tone", int'(tone_o), 0);
    rst_n = 1'b1;
    cyc(); cyc();
    check("R7 no step before sync release", int'(step_o), 0);
    cyc();
    check("R7 first step after third edge", int'(step_o), 1);
    check("R7 first phase", int'(phase_o), 1);

    // R1: mean step rate per tone
    for (int t = 0; t < 4; t++) begin
      {mode, data} = 2'(t);
      do cyc(); while (!step_o);
      check("R1 tone index", int'(tone_o), t);
      cycles = 0;
      for (int s = 0; s < 128; s++) begin
        do begin cyc(); cycles++; end while (!step_o);
      end
      expc = 128.0 * real'(CLK_HZ) / (32.0 * real'(freq_tab[t]));
      checks++;
      if (real'(cycles) > expc + 2.0 || real'(cycles) < expc - 2.0) begin
        errors++;
        $display("FAIL R1 mean rate tone %0d: actual %0d expected %0f", t, cycles, expc);
      end
    end

    // R5: change on the boundary cycle versus one cycle after it
    for (int k = 0; k < 16; k++) begin
      while (m_cnt != 0) cyc();
      data = ~data;
      sel_new = {mode, data};
      cyc();
      check("R5 change on boundary taken", int'(tone_o), sel_new);
      data = ~data;
      cyc();
      check("R5 change after boundary held off", int'(tone_o), sel_new);
      if (k % 4 == 3) mode = ~mode;
    end

    // constrained random traffic with boundary-aligned toggles
    for (int i = 0; i < 60000; i++) begin
      r = $urandom;
      if (m_cnt == 0 && (r % 4) == 0) data = ~data;
      else if ((r % 64) == 1) {mode, data} = 2'($urandom % 4);
      cyc();
    end

    // R7: reset in mid-run
    rst_n = 1'b0;
    cyc(); cyc();
    check("R7 mid reset phase", int'(phase_o), 0);
    check("R7 mid reset tone", int'(tone_o), 0);
    check("R7 mid reset sample", int'(sample_o), 0);
    rst_n = 1'b1;
    cyc(); cyc();
    check("R7 quiet after mid reset", int'(step_o), 0);
    cyc();
    check("R7 step after mid reset", int'(step_o), 1);
    repeat (500) cyc();

    summary();
    $finish;
  end

endmodule